// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. After a start command it walks through a run of input channels, one after another. Each channel gets a fixed-length acquisition window made of an initial sample stretch, a transfer stretch and a final sample stretch. A binary search follows, one bit per clock. The block drives a trial code to the external DAC and reads back one comparator bit. At the end of each channel it stores the settled code, raises that channel's completion flag, and moves to the next channel.

The run length is chosen at start: either the lower half or all of the channels. The resolution is also chosen at start: the full 10 bits, or 8 bits left-justified in the 10-bit field with the two low bits forced to zero. A sequence-complete flag goes up and the block returns to idle once the last channel of the run is stored. Results are read back through a channel-indexed combinational read port.

Top module: `sar_seq`

## Requirements
- R1: After reset the block is idle: busy is 0, every completion flag is 0, the sequence flag is 0, the trial code is 0, the channel select is 0 and every stored result reads as 0.
- R2: A start pulse seen while idle begins a sequence and clears all completion flags and the sequence flag on the next clock; a start pulse while busy has no effect on the running sequence or on the flags.
- R3: Each channel spends 2 clocks in initial sample, 4 in transfer and 2 in final sample (8 clocks, busy high) before the first trial code appears.
- R4: On the first resolution clock the trial code has only bit 9 set.
- R5: Each resolution clock decides one bit from the top down: a comparator value of 1 (analog input at or above the trial code) keeps the bit under test, 0 clears it, and the next lower bit is set for trial.
- R6: With res10=1 the search covers bits 9..0 (10 clocks); with res10=0 it covers bits 9..2 (8 clocks) and bits 1..0 of the trial code and result stay 0.
- R7: One end clock follows the last bit; during it the trial code holds the final result, and after it the result is stored for that channel and its completion flag ccf[channel] is 1.
- R8: Channels are converted in ascending order starting at 0, and chan_sel shows the channel in progress.
- R9: With mode8ch=0 the sequence stops after channel 3, with mode8ch=1 after channel 7; then seq_done is 1, busy is 0, chan_sel returns to 0 and flags of unconverted channels stay 0.
- R10: rd_data shows, combinationally, the stored result of channel rd_ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken only while idle |
| mode8ch | input | 1 | 1: eight-channel run, 0: four-channel run (latched at start) |
| res10 | input | 1 | 1: 10-bit, 0: 8-bit left-justified (latched at start) |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the trial code |
| rd_ch | input | 3 | Result read channel |
| trial_code | output | 10 | Code driven to the DAC |
| chan_sel | output | 3 | Channel being converted |
| busy | output | 1 | Sequence in progress |
| ccf | output | 8 | Per-channel completion flags |
| seq_done | output | 1 | Sequence complete |
| rd_data | output | 10 | Stored result of channel rd_ch |

## Verification
The bench models the comparator against one target per channel. It picks targets at zero, full scale and the mid-scale neighbours 511 and 512. A design that mishandles the top or bottom bit, or that sets the next trial bit on the last step, then shows a one-off or stuck code. Both run lengths are paired with both resolutions. A design that resolves two bits too many in 8-bit mode, or stops at the wrong channel, shifts every later flag edge by clocks that the per-cycle comparison catches. A start pulse is injected mid-sequence, and a design that restarts or clears flags on it diverges from the model at once.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_INIT, PH_XFER, PH_FINAL, PH_RES, PH_END
  } phase_t;

  // lowest resolved bit position for the chosen resolution
  function automatic int unsigned low_bit(input logic full_res, input int unsigned width,
                                          input int unsigned short_width);
    return full_res ? 0 : width - short_width;
  endfunction
endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int CH_MAX     = 8,
  parameter int RES_W      = 10,
  parameter int SHORT_W    = 8,
  parameter int INIT_SAMP  = 2,
  parameter int XFER_LEN   = 4,
  parameter int FINAL_SAMP = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       mode8ch,
  input  logic                       res10,
  output phase_t                     phase,
  output logic [$clog2(RES_W)-1:0]   bitpos,
  output logic [$clog2(RES_W)-1:0]   lsb,
  output logic [$clog2(CH_MAX)-1:0]  chan,
  output logic                       res_q,
  output logic                       start_acc,
  output logic                       load_sar,
  output logic                       conv_end,
  output logic                       seq_fin
);
  localparam int BPW   = $clog2(RES_W);
  localparam int CHW   = $clog2(CH_MAX);
  localparam int MAXP  = (INIT_SAMP > XFER_LEN) ?
                         ((INIT_SAMP > FINAL_SAMP) ? INIT_SAMP : FINAL_SAMP) :
                         ((XFER_LEN > FINAL_SAMP) ? XFER_LEN : FINAL_SAMP);
  localparam int CNTW  = $clog2(MAXP + 1);

  logic [CNTW-1:0] cnt;
  logic            mode_q;
  logic            phase_done;
  logic            last_ch;
  int unsigned     cur_len;

  always_comb begin
    unique case (phase)
      PH_INIT:  cur_len = INIT_SAMP;
      PH_XFER:  cur_len = XFER_LEN;
      PH_FINAL: cur_len = FINAL_SAMP;
      default:  cur_len = 1;
    endcase
  end

  assign phase_done = (cnt == CNTW'(cur_len - 1));
  assign lsb        = BPW'(low_bit(res_q, RES_W, SHORT_W));
  assign last_ch    = (chan == (mode_q ? CHW'(CH_MAX - 1) : CHW'(CH_MAX / 2 - 1)));
  assign start_acc  = start && (phase == PH_IDLE);
  assign load_sar   = (phase == PH_FINAL) && phase_done;
  assign conv_end   = (phase == PH_END);
  assign seq_fin    = conv_end && last_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      chan   <= '0;
      bitpos <= '0;
      mode_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_INIT;
          cnt    <= '0;
          chan   <= '0;
          mode_q <= mode8ch;
          res_q  <= res10;
        end
        PH_INIT: if (phase_done) begin phase <= PH_XFER; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        PH_XFER: if (phase_done) begin phase <= PH_FINAL; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        PH_FINAL: if (phase_done) begin
          phase  <= PH_RES;
          cnt    <= '0;
          bitpos <= BPW'(RES_W - 1);
        end else cnt <= cnt + 1'b1;
        PH_RES: if (bitpos == lsb) phase <= PH_END;
                else bitpos <= bitpos - 1'b1;
        PH_END: if (last_ch) begin
          phase <= PH_IDLE;
          chan  <= '0;
        end else begin
          phase <= PH_INIT;
          cnt   <= '0;
          chan  <= chan + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int RES_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     step,
  input  logic [$clog2(RES_W)-1:0] bitpos,
  input  logic [$clog2(RES_W)-1:0] lsb,
  input  logic                     cmp_hi,
  output logic [RES_W-1:0]         sar
);
  localparam int BPW = $clog2(RES_W);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  // decide the bit under test, then arm the next lower one
  function automatic logic [RES_W-1:0] trial_step(input logic [RES_W-1:0] cur,
                                                  input logic [BPW-1:0] pos,
                                                  input logic keep,
                                                  input logic [BPW-1:0] low);
    logic [RES_W-1:0] nxt;
    nxt      = cur;
    nxt[pos] = keep;
    if (pos > low) nxt[pos - 1'b1] = 1'b1;
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sar <= '0;
    else if (load) sar <= MSB_ONLY;
    else if (step) sar <= trial_step(sar, bitpos, cmp_hi, lsb);
  end
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int CH_MAX = 8,
  parameter int RES_W  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      wr,
  input  logic [$clog2(CH_MAX)-1:0] wr_ch,
  input  logic [RES_W-1:0]          wr_data,
  input  logic                      seq_fin,
  input  logic [$clog2(CH_MAX)-1:0] rd_ch,
  output logic [RES_W-1:0]          rd_data,
  output logic [CH_MAX-1:0]         ccf,
  output logic                      seq_done
);
  logic [RES_W-1:0] res_q [CH_MAX];

  for (genvar g = 0; g < CH_MAX; g++) begin : g_slot
    logic hit;
    assign hit = wr && (wr_ch == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[g] <= '0;
        ccf[g]   <= 1'b0;
      end else begin
        if (hit)        res_q[g] <= wr_data;
        if (clear)      ccf[g]   <= 1'b0;
        else if (hit)   ccf[g]   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seq_done <= 1'b0;
    else if (clear)   seq_done <= 1'b0;
    else if (seq_fin) seq_done <= 1'b1;
  end

  assign rd_data = res_q[rd_ch];
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int CH_MAX     = 8,
  parameter int RES_W      = 10,
  parameter int SHORT_W    = 8,
  parameter int INIT_SAMP  = 2,
  parameter int XFER_LEN   = 4,
  parameter int FINAL_SAMP = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      mode8ch,
  input  logic                      res10,
  input  logic                      cmp_hi,
  input  logic [$clog2(CH_MAX)-1:0] rd_ch,
  output logic [RES_W-1:0]          trial_code,
  output logic [$clog2(CH_MAX)-1:0] chan_sel,
  output logic                      busy,
  output logic [CH_MAX-1:0]         ccf,
  output logic                      seq_done,
  output logic [RES_W-1:0]          rd_data
);
  localparam int BPW = $clog2(RES_W);

  phase_t         phase;
  logic [BPW-1:0] bitpos, lsb;
  logic           res_q, start_acc, load_sar, conv_end, seq_fin, in_res;

  sar_phase_ctrl #(
    .CH_MAX(CH_MAX), .RES_W(RES_W), .SHORT_W(SHORT_W),
    .INIT_SAMP(INIT_SAMP), .XFER_LEN(XFER_LEN), .FINAL_SAMP(FINAL_SAMP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode8ch(mode8ch), .res10(res10),
    .phase(phase), .bitpos(bitpos), .lsb(lsb), .chan(chan_sel), .res_q(res_q),
    .start_acc(start_acc), .load_sar(load_sar), .conv_end(conv_end), .seq_fin(seq_fin)
  );

  assign in_res = (phase == PH_RES);
  assign busy   = (phase != PH_IDLE);

  sar_register #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .load(load_sar), .step(in_res),
    .bitpos(bitpos), .lsb(lsb), .cmp_hi(cmp_hi), .sar(trial_code)
  );

  sar_result_bank #(.CH_MAX(CH_MAX), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .wr(conv_end), .wr_ch(chan_sel),
    .wr_data(trial_code), .seq_fin(seq_fin), .rd_ch(rd_ch), .rd_data(rd_data),
    .ccf(ccf), .seq_done(seq_done)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int CH_MAX  = 8,
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      busy,
  input logic                      start_acc,
  input logic                      conv_end,
  input logic                      in_res,
  input logic                      res_q,
  input logic [$clog2(CH_MAX)-1:0] chan_sel,
  input logic [CH_MAX-1:0]         ccf,
  input logic                      seq_done,
  input logic [RES_W-1:0]          trial_code
);
  localparam int LOWB = RES_W - SHORT_W;
  localparam logic [RES_W-1:0] LOW_MASK = RES_W'((1 << LOWB) - 1);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (ccf == '0) && !seq_done && (chan_sel == '0) && busy);

  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (($past(ccf) & ~ccf) == '0));

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_res) |-> (trial_code == MSB_ONLY));

  // R6
  short_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_res || conv_end) && !res_q) |-> ((trial_code & LOW_MASK) == '0));

  // R7
  flag_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> ccf[$past(chan_sel)]);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !busy);
endmodule

bind sar_seq sar_seq_chk #(.CH_MAX(CH_MAX), .RES_W(RES_W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .start_acc(start_acc),
  .conv_end(conv_end), .in_res(in_res), .res_q(res_q), .chan_sel(chan_sel),
  .ccf(ccf), .seq_done(seq_done), .trial_code(trial_code)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, mode8ch = 1'b0, res10 = 1'b0;
  logic [2:0] rd_ch = '0;
  logic       cmp_hi;
  logic [9:0] trial_code, rd_data;
  logic [2:0] chan_sel;
  logic       busy, seq_done;
  logic [7:0] ccf;
  logic [9:0] tgt [8];
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  assign cmp_hi = (tgt[chan_sel] >= trial_code);

  sar_seq u_sar_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode8ch(mode8ch), .res10(res10),
    .cmp_hi(cmp_hi), .rd_ch(rd_ch), .trial_code(trial_code), .chan_sel(chan_sel),
    .busy(busy), .ccf(ccf), .seq_done(seq_done), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int aligned(input int v, input bit full);
    return full ? v : (v / 4) * 4;
  endfunction

  // value of the top k bits of a 10-bit number, lower bits zero
  function automatic int top_bits(input int v, input int k);
    int w;
    w = 1 << (10 - k);
    return (v / w) * w;
  endfunction

  task automatic run_seq(input bit m8, input bit full);
    int nch, nb, len, total;
    nch = m8 ? 8 : 4;
    nb  = full ? 10 : 8;
    len = 8 + nb + 1;
    total = nch * len;
    @(negedge clk);
    mode8ch = m8; res10 = full; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < total + 3; p++) begin
      int ch, off, eccf;
      bit act;
      act = (p < total);
      ch  = act ? p / len : 0;
      off = p % len;
      eccf = 0;
      for (int c = 0; c < nch; c++) if (p >= (c + 1) * len) eccf |= (1 << c);
      chk("R2/R3 busy", busy, act);
      chk("R8 chan_sel", chan_sel, ch);
      chk("R7/R9 ccf", ccf, eccf);
      chk("R9 seq_done", seq_done, !act);
      if (act && off >= 8) begin
        int k, res;
        k = off - 8;
        res = aligned(tgt[ch], full);
        if (k < nb) chk(k == 0 ? "R4 first trial" : "R5/R6 trial step",
                        trial_code, top_bits(res, k) + (1 << (9 - k)));
        else chk("R7 end-cycle code", trial_code, res);
      end
      start = (p == 15) || (p == total - 1 - len); // ignored while busy: R2
      @(posedge clk);
      @(negedge clk);
    end
    start = 1'b0;
    for (int c = 0; c < nch; c++) begin
      rd_ch = 3'(c);
      #1;
      chk("R10 result read", rd_data, aligned(tgt[c], full));
    end
  endtask

  initial begin
    #(200000 * 20);
    nchk++; nerr++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    tgt = '{10'd0, 10'd1023, 10'd512, 10'd511, 10'd1, 10'd682, 10'd341, 10'd3};
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 ccf", ccf, 0);
    chk("R1 seq_done", seq_done, 0);
    chk("R1 trial", trial_code, 0);
    chk("R1 chan_sel", chan_sel, 0);
    for (int c = 0; c < 8; c++) begin
      rd_ch = 3'(c); #1; chk("R1 result", rd_data, 0);
    end
    run_seq(1'b1, 1'b1);
    tgt = '{10'd1023, 10'd2, 10'd7, 10'd770, 10'd0, 10'd0, 10'd0, 10'd0};
    run_seq(1'b0, 1'b0);
    tgt = '{10'd513, 10'd256, 10'd1022, 10'd5, 10'd9, 10'd9, 10'd9, 10'd9};
    run_seq(1'b0, 1'b1);
    tgt = '{10'd4, 10'd1019, 10'd515, 10'd508, 10'd3, 10'd1023, 10'd64, 10'd0};
    run_seq(1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule